// File: doc/BRIEF.md
# Debounced Single-Pulse Generator

This block turns the bouncing signal of a mechanical push button or relay contact into one clean pulse per operation. The raw contact first passes through a short clock-domain synchronizer. It then enters a chain of two identical debounce stages. Each stage moves its level only after its input has disagreed with it for a fixed number of consecutive sampling ticks. The second stage takes the first stage's level as its input, so it repeats every transition of the first stage a fixed number of ticks later.

While the two stage levels disagree, a window opens. A NOR of one stage level with the inverse of the other turns that window into a pulse. The pulse is registered, so it carries no glitches. A mode input picks which stage is inverted. In make mode the pulse fires when the contact closes. In break mode it fires when the contact opens.

The contact is active-low: a closed contact reads 0. The sampling tick is a single-clock strobe from elsewhere in the chip. The tick period sets the debounce time and the pulse width.

Top module: `bounce_pulse_gen`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, both stage levels read 1, the pulse reads 0 and every synchronizer flop holds 1.
- R2: The contact reaches the first debounce stage through SYNC_STAGES (default 2) clocked flops. A change at the pin is first seen by the stage at the edge after SYNC_STAGES edges.
- R3: A stage level changes only at a clock edge with the tick high. It changes at the DEPTH-th (default 4) consecutive tick at which the stage input differs from the level. The new level equals the input. Any tick at which the input equals the level restarts the count.
- R4: The second stage's input is the first stage's level. A clean change of the first stage therefore appears on the second stage exactly DEPTH ticks later.
- R5: With mode = 0 (make), the pulse at each edge takes the value (stage1 = 0 AND stage2 = 1) from before that edge. It is 1 after a contact closure and stays 0 on a release.
- R6: With mode = 1 (break), the pulse at each edge takes the value (stage1 = 1 AND stage2 = 0) from before that edge. It is 1 after a contact release and stays 0 on a closure.
- R7: A clean contact operation in the selected direction gives exactly one pulse. The pulse lasts DEPTH tick periods, which is DEPTH × (tick period) clocks.
- R8: A disturbance that holds the contact away from its settled level for fewer than DEPTH consecutive ticks changes no stage level and gives no pulse. A bouncing closure that then settles gives exactly one pulse in make mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| contact_n | input | 1 | Raw contact, 0 = closed, asynchronous |
| tick | input | 1 | Sampling strobe, one clock wide, at least two clocks apart |
| mode | input | 1 | Trigger select: 0 = fire on make, 1 = fire on break |
| pulse | output | 1 | Registered one-shot output |
| stage1_lvl | output | 1 | Level of the first debounce stage |
| stage2_lvl | output | 1 | Level of the second debounce stage |

## Verification
A contact change reaches the first stage two clocks later. The first stage level moves on the fourth qualifying tick after that. The second stage follows four ticks after the first. The pulse moves one clock after whichever stage level changes. The bench's behavioural model applies these latencies on each rising edge. It then compares all three outputs at the falling edge, when every register on the path has settled. Pulse count, pulse width in clocks and the lag between the two stages are then measured at the ports. They are checked against DEPTH × 4 clocks for a tick period of four clocks.

// File: rtl/bounce_pulse_pkg.sv
// Package: shared types and defaults for the debounced single-pulse generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bounce_pulse_pkg;

    // Trigger direction selected by the mode pin.
    typedef enum logic {
        TRIG_MAKE  = 1'b0,
        TRIG_BREAK = 1'b1
    } trig_e;

    // Default number of consecutive disagreeing ticks before a stage moves.
    localparam int unsigned DEF_DEPTH       = 4;
    // Default synchronizer length on the raw contact.
    localparam int unsigned DEF_SYNC_STAGES = 2;
    // Level a released (open) contact reads.
    localparam logic        IDLE_LEVEL      = 1'b1;

endpackage

// File: rtl/contact_sync.sv
// Module: contact_sync
// Brings the asynchronous contact into the clock domain through a chain
// of flops. Assumes SYNC_STAGES >= 1. Reset fills the chain with the idle
// (open contact) level, so a released contact causes no transition at reset.
module contact_sync
    import bounce_pulse_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [SYNC_STAGES-1:0] chain_q;

    // Shift the contact through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {SYNC_STAGES{IDLE_LEVEL}};
        end else begin
            chain_q <= {chain_q, async_in};
        end
    end

    assign sync_out = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/debounce_stage.sv
// Module: debounce_stage
// One debounce stage. On each tick the input is compared with the held
// level. DEPTH consecutive disagreeing ticks make the level take the
// input. A single agreeing tick clears the run. Assumes DEPTH >= 1 and a
// tick input already synchronous to clk.
module debounce_stage
    import bounce_pulse_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic level
);

    localparam int unsigned CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] run_q;
    logic          level_q;
    logic          differs;

    // Disagreement between the stage input and the held level.
    assign differs = (din != level_q);

    // Count disagreeing ticks and move the level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= IDLE_LEVEL;
        end else if (tick) begin
            if (!differs) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                run_q   <= '0;
                level_q <= din;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level = level_q;

endmodule

// File: rtl/pulse_shaper.sv
// Module: pulse_shaper
// Forms the one-shot from the early and late stage levels. Make mode
// inverts the late level and break mode inverts the early level. The two
// are then NORed, and the result is registered so that the output is free
// of glitches. Assumes both levels are registers in the same clock domain.
module pulse_shaper
    import bounce_pulse_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_e mode,
    input  logic  early_lvl,
    input  logic  late_lvl,
    output logic  pulse
);

    logic nor_a;
    logic nor_b;
    logic fire;
    logic pulse_q;

    // Pick which stage level is inverted before the NOR.
    always_comb begin
        if (mode == TRIG_MAKE) begin
            nor_a = early_lvl;
            nor_b = ~late_lvl;
        end else begin
            nor_a = ~early_lvl;
            nor_b = late_lvl;
        end
        fire = ~(nor_a | nor_b);
    end

    // Register the NOR result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/bounce_pulse_gen.sv
// Module: bounce_pulse_gen (top)
// Synchronizer followed by a chain of debounce stages and the pulse shaper.
// Stage k takes stage k-1's level, so each stage lags the previous one by
// DEPTH ticks. Assumes an active-low contact and a one-clock tick.
module bounce_pulse_gen
    import bounce_pulse_pkg::*;
#(
    parameter int unsigned DEPTH       = DEF_DEPTH,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic contact_n,
    input  logic tick,
    input  logic mode,
    output logic pulse,
    output logic stage1_lvl,
    output logic stage2_lvl
);

    localparam int unsigned NUM_STAGES = 2;

    logic [NUM_STAGES:0] chain;
    trig_e               mode_sel;

    // Cast the mode pin to the trigger type.
    assign mode_sel = trig_e'(mode);

    contact_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (contact_n),
        .sync_out (chain[0])
    );

    // Cascade of debounce stages, each fed by the previous stage's level.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        debounce_stage #(
            .DEPTH (DEPTH)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .din   (chain[i]),
            .level (chain[i+1])
        );
    end

    pulse_shaper u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_sel),
        .early_lvl (chain[1]),
        .late_lvl  (chain[2]),
        .pulse     (pulse)
    );

    assign stage1_lvl = chain[1];
    assign stage2_lvl = chain[2];

endmodule

// File: rtl/bounce_pulse_chk.sv
// Module: bounce_pulse_chk
// Property checker bound to bounce_pulse_gen. Assumes ticks are at least
// two clocks apart, which the pulse window count relies on.
module bounce_pulse_chk #(
    parameter int unsigned DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic pulse,
    input logic stage1_lvl,
    input logic stage2_lvl
);

    localparam int unsigned WW = $clog2(DEPTH + 2);

    logic [WW-1:0] win_q;

    // Count the ticks seen while the pulse is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulse) begin
            win_q <= '0;
        end else if (tick && (win_q != WW'(DEPTH + 1))) begin
            win_q <= win_q + 1'b1;
        end
    end

    // R3
    stage_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage1_lvl != $past(stage1_lvl)) || (stage2_lvl != $past(stage2_lvl))) |-> $past(tick));

    // R4
    stage2_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage2_lvl != $past(stage2_lvl)) |-> (stage2_lvl == $past(stage1_lvl)));

    // R5
    pulse_needs_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> ($past(stage1_lvl) != $past(stage2_lvl)));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_q <= WW'(DEPTH));

    // R8
    settled_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage1_lvl) == $past(stage2_lvl)) && (stage1_lvl == stage2_lvl) |=> !pulse);

endmodule

bind bounce_pulse_gen bounce_pulse_chk #(
    .DEPTH (DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pulse      (pulse),
    .stage1_lvl (stage1_lvl),
    .stage2_lvl (stage2_lvl)
);

// File: tb/sim_bounce_pulse_gen.sv
`timescale 1ns/1ps
module sim_bounce_pulse_gen;

    localparam int DEPTH = 4;
    localparam int SYNC  = 2;
    localparam int DIV   = 4;
    localparam int WDOG  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic contact_n = 1'b1;
    logic tick = 1'b0;
    logic mode = 1'b0;
    logic pulse, stage1_lvl, stage2_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bounce_pulse_gen #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .contact_n(contact_n), .tick(tick),
        .mode(mode), .pulse(pulse), .stage1_lvl(stage1_lvl), .stage2_lvl(stage2_lvl)
    );

    always #5 clk = ~clk;

    // Tick strobe, one clock in DIV, driven away from the active edge.
    int div_cnt = 0;
    always @(negedge clk) begin
        div_cnt = (div_cnt + 1) % DIV;
        tick = (div_cnt == 0);
    end

    // Behavioural reference: queues of samples and a history window per stage.
    logic sq[$];
    logic h1[$];
    logic h2[$];
    logic m_s1 = 1'b1, m_s2 = 1'b1, m_p = 1'b0;

    function automatic bit all_differ(input logic h[$], input logic lvl);
        if (h.size() < DEPTH) return 0;
        foreach (h[k]) if (h[k] == lvl) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        logic s1_old, s2_old, syn_old;
        s1_old = m_s1;
        s2_old = m_s2;
        if (!rst_n) begin
            sq.delete();
            for (int k = 0; k < SYNC; k++) sq.push_back(1'b1);
            h1.delete(); h2.delete();
            m_s1 = 1'b1; m_s2 = 1'b1; m_p = 1'b0;
        end else begin
            syn_old = sq[0];
            m_p = mode ? (s1_old && !s2_old) : (!s1_old && s2_old);
            if (tick) begin
                h1.push_back(syn_old); if (h1.size() > DEPTH) void'(h1.pop_front());
                h2.push_back(s1_old);  if (h2.size() > DEPTH) void'(h2.pop_front());
                if (all_differ(h1, s1_old)) begin m_s1 = syn_old; h1.delete(); end
                if (all_differ(h2, s2_old)) begin m_s2 = s1_old; h2.delete(); end
            end
            void'(sq.pop_front());
            sq.push_back(contact_n);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, plus port-level pulse measurement.
    int pcount = 0, cur_w = 0, last_w = 0;
    bit prev_p = 0, s1_went_low = 0;
    int t_s1 = 0, t_s2 = 0, cyc = 0;
    bit prev_s1 = 1, prev_s2 = 1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(stage1_lvl === m_s1, "R2 R3 stage1", int'(stage1_lvl), int'(m_s1));
            chk(stage2_lvl === m_s2, "R4 stage2", int'(stage2_lvl), int'(m_s2));
            chk(pulse === m_p, mode ? "R6 pulse" : "R5 pulse", int'(pulse), int'(m_p));
        end
        if (pulse && !prev_p) pcount++;
        if (pulse) cur_w++;
        if (!pulse && prev_p) begin last_w = cur_w; cur_w = 0; end
        if (!stage1_lvl) s1_went_low = 1;
        if (stage1_lvl != prev_s1) t_s1 = cyc;
        if (stage2_lvl != prev_s2) t_s2 = cyc;
        prev_p = pulse; prev_s1 = stage1_lvl; prev_s2 = stage2_lvl;
    end

    task automatic hold(input logic v, input int ticks);
        @(negedge clk);
        contact_n = v;
        repeat (ticks * DIV - 1) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        // R1: outputs during and after reset.
        chk(stage1_lvl === 1'b1 && stage2_lvl === 1'b1, "R1 levels", int'({stage1_lvl, stage2_lvl}), 3);
        chk(pulse === 1'b0, "R1 pulse", int'(pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stage1_lvl === 1'b1 && stage2_lvl === 1'b1 && pulse === 1'b0, "R1 after", int'({stage1_lvl, stage2_lvl, pulse}), 6);
        hold(1'b1, 6);

        // Make mode, clean closure then release.
        pcount = 0;
        hold(1'b0, 14);
        chk(pcount == 1, "R5 R7 make count", pcount, 1);
        chk(last_w == DEPTH * DIV, "R7 width", last_w, DEPTH * DIV);
        chk(t_s2 - t_s1 == DEPTH * DIV, "R4 lag", t_s2 - t_s1, DEPTH * DIV);
        hold(1'b1, 14);
        chk(pcount == 1, "R5 no pulse on release", pcount, 1);

        // Short glitch: three ticks closed.
        pcount = 0; s1_went_low = 0;
        hold(1'b0, DEPTH - 1);
        hold(1'b1, 14);
        chk(pcount == 0, "R8 glitch pulse", pcount, 0);
        chk(s1_went_low == 0, "R8 glitch stage", int'(s1_went_low), 0);
        chk(stage1_lvl === 1'b1 && stage2_lvl === 1'b1, "R3 stages idle", int'({stage1_lvl, stage2_lvl}), 3);

        // Bouncing closure that settles.
        pcount = 0;
        hold(1'b0, 1); hold(1'b1, 1); hold(1'b0, 2); hold(1'b1, 1);
        hold(1'b0, 3); hold(1'b1, 1); hold(1'b0, 16);
        chk(pcount == 1, "R8 bouncy make", pcount, 1);
        chk(last_w == DEPTH * DIV, "R7 bouncy width", last_w, DEPTH * DIV);
        hold(1'b1, 14);

        // Break mode.
        mode = 1'b1;
        pcount = 0;
        hold(1'b0, 14);
        chk(pcount == 0, "R6 no pulse on closure", pcount, 0);
        hold(1'b1, 14);
        chk(pcount == 1, "R6 R7 break count", pcount, 1);
        chk(last_w == DEPTH * DIV, "R7 break width", last_w, DEPTH * DIV);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule